// File: doc/BRIEF.md
# Host Memory Window Address Translator

This block sits behind a small host-visible memory aperture and turns every host access into an access on an internal system backplane. The host presents an offset within the aperture together with a read or write strobe. One registered cycle later the block reports which target the access lands on and the address to use there. The possible targets are a sliding window onto an arbitrary backplane page, the serial configuration PROM, the local bridge core, or the common core.

Three address maps are available, chosen by a static layout input. The first is a compact 8 KB map. The second is a 16 KB map with fixed PROM, bridge and common regions. The third is a 16 KB map with two independent 4 KB sliding windows. The backplane page under each sliding window is set by a software-writable window register. The bottom 4 KB of the aperture is always a sliding window over the first window register. Offsets that fall outside the active map are flagged as errors.

Top module: `bar_xlate`

## Requirements
- R1: After reset, both window registers read back 0, `out_valid` is 0, `out_tgt` is 0 (none) and `out_err` is 0.
- R2: A write to window register 0 or 1 (`cfg_wr_sel`) stores the data with its low 12 bits forced to zero. The other register is unchanged, and `cfg_rd_data` returns the selected register.
- R3: In every defined layout, offsets 0x0000–0x0FFF give target code 1 (sliding window) with address = window register 0 | offset[11:0].
- R4: Layout 0 (8 KB) maps 0x1000–0x17FF to target code 2 (PROM) with address = offset − 0x1000.
- R5: Layout 0 maps 0x1800–0x1BFF to target code 3 (bridge core) at addresses 0x000–0x3FF, and maps 0x1C00–0x1FFF to target code 3 at addresses 0xC00–0xFFF.
- R6: In layout 0, offsets 0x2000 and above raise `out_err`, with target code 0 and address 0.
- R7: Layout 1 (16 KB) maps 0x1000–0x1FFF to PROM (code 2), 0x2000–0x2FFF to bridge core (code 3) and 0x3000–0x3FFF to common core (code 4). The address is offset & 0xFFF in each case.
- R8: Layout 2 (dual window) maps 0x1000–0x1FFF to target code 1 with address = window register 1 | offset[11:0], and 0x2000–0x2FFF to bridge core (code 3) with address offset & 0xFFF.
- R9: In layout 2, 0x3800–0x3FFF goes to the PROM (code 2, address offset − 0x3800) only while `prom_cap` is 1. Otherwise it goes to the common core (code 4, address offset − 0x3000). The range 0x3000–0x37FF always goes to the common core.
- R10: A strobe on `acc_rd` or `acc_wr` produces `out_valid` on the following clock edge, with `out_write` equal to the sampled `acc_wr`. A cycle without a strobe gives `out_valid`=0, code 0, address 0 and no error.
- R11: An access presented in the same cycle as a window register write is translated with the register's previous value.
- R12: Layout value 3 is reserved: every access in it raises `out_err` with target code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout_sel | input | 2 | Address map: 0 = 8 KB, 1 = 16 KB, 2 = 16 KB dual window, 3 = reserved |
| prom_cap | input | 1 | PROM-present capability (used by layout 2) |
| cfg_wr_en | input | 1 | Window register write strobe |
| cfg_wr_sel | input | 1 | Window register select for write |
| cfg_wr_data | input | 32 | Window register write data |
| cfg_rd_sel | input | 1 | Window register select for read back |
| cfg_rd_data | output | 32 | Selected window register value |
| acc_off | input | 14 | Host offset within the aperture |
| acc_rd | input | 1 | Host read strobe |
| acc_wr | input | 1 | Host write strobe |
| out_valid | output | 1 | Translated access present |
| out_write | output | 1 | Translated access is a write |
| out_tgt | output | 3 | Target code: 0 none, 1 window, 2 PROM, 3 bridge, 4 common |
| out_addr | output | 32 | Translated address |
| out_err | output | 1 | Unmapped offset or reserved layout |

## Verification
The assertions assume that `layout_sel` and `prom_cap` are held steady around any access. They also assume that `acc_rd` and `acc_wr` are never high together. Under those assumptions, the registered target and address can be related to the offset sampled one cycle earlier. The bench changes the layout and the capability input only on cycles without a strobe, and it never raises both strobes at once. Each access is therefore judged against a single, stable map.

// File: rtl/bar_xlate_pkg.sv
package bar_xlate_pkg;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_WIN    = 3'd1,
    TGT_PROM   = 3'd2,
    TGT_BRIDGE = 3'd3,
    TGT_COMMON = 3'd4
  } tgt_e;

  localparam logic [1:0] LAY_8K   = 2'd0;
  localparam logic [1:0] LAY_16K  = 2'd1;
  localparam logic [1:0] LAY_DUAL = 2'd2;

  localparam int PAGE_W = 12;

endpackage

// File: rtl/bar_xlate_winregs.sv
module bar_xlate_winregs
  import bar_xlate_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NWIN = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NWIN)-1:0]    wr_sel,
  input  logic [AW-1:0]              wr_data,
  input  logic [$clog2(NWIN)-1:0]    rd_sel,
  output logic [AW-1:0]              rd_data,
  output logic [NWIN-1:0][AW-1:0]    win
);

  localparam logic [AW-1:0] ALIGN = {{(AW-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic [NWIN-1:0][AW-1:0] win_nxt;
  logic [NWIN-1:0]         win_en;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_comb begin
      win_en[g]  = wr_en && (wr_sel == g);
      win_nxt[g] = wr_data & ALIGN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[g] <= '0;
      end else if (win_en[g]) begin
        win[g] <= win_nxt[g];
      end
    end

    // R2: an unselected register keeps its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == g) |=> $stable(win[g]));
    // R2: the stored value is page aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      win[g][PAGE_W-1:0] == '0);
  end

  always_comb rd_data = win[rd_sel];

endmodule

// File: rtl/bar_xlate_decode.sv
module bar_xlate_decode
  import bar_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 14
) (
  input  logic [1:0]    layout,
  input  logic          prom_cap,
  input  logic          req,
  input  logic [OW-1:0] off,
  input  logic [AW-1:0] win0,
  input  logic [AW-1:0] win1,
  output tgt_e          tgt,
  output logic [AW-1:0] addr,
  output logic          err
);

  localparam logic [AW-1:0] ALIGN = {{(AW-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic [OW-PAGE_W-1:0] page;
  logic [PAGE_W-1:0]    lo;
  logic [PAGE_W-1:0]    loc;
  logic                 use_win;
  logic                 sel_hi;
  logic [AW-1:0]        base;

  always_comb begin
    page    = off[OW-1:PAGE_W];
    lo      = off[PAGE_W-1:0];
    tgt     = TGT_NONE;
    loc     = '0;
    err     = 1'b0;
    use_win = 1'b0;
    sel_hi  = 1'b0;
    if (req) begin
      case (layout)
        LAY_8K: begin
          case (page)
            2'd0: begin tgt = TGT_WIN; use_win = 1'b1; end
            2'd1: begin
              if (!lo[11]) begin
                tgt = TGT_PROM;
                loc = {1'b0, lo[10:0]};
              end else if (!lo[10]) begin
                tgt = TGT_BRIDGE;
                loc = {2'b00, lo[9:0]};
              end else begin
                tgt = TGT_BRIDGE;
                loc = {2'b11, lo[9:0]};
              end
            end
            default: err = 1'b1;
          endcase
        end
        LAY_16K: begin
          case (page)
            2'd0: begin tgt = TGT_WIN; use_win = 1'b1; end
            2'd1: begin tgt = TGT_PROM;   loc = lo; end
            2'd2: begin tgt = TGT_BRIDGE; loc = lo; end
            default: begin tgt = TGT_COMMON; loc = lo; end
          endcase
        end
        LAY_DUAL: begin
          case (page)
            2'd0: begin tgt = TGT_WIN; use_win = 1'b1; end
            2'd1: begin tgt = TGT_WIN; use_win = 1'b1; sel_hi = 1'b1; end
            2'd2: begin tgt = TGT_BRIDGE; loc = lo; end
            default: begin
              if (lo[11] && prom_cap) begin
                tgt = TGT_PROM;
                loc = {1'b0, lo[10:0]};
              end else begin
                tgt = TGT_COMMON;
                loc = lo;
              end
            end
          endcase
        end
        default: err = 1'b1;
      endcase
    end
    base = sel_hi ? win1 : win0;
    addr = use_win ? ((base & ALIGN) | AW'(lo)) : AW'(loc);
  end

endmodule

// File: rtl/bar_xlate_outreg.sv
module bar_xlate_outreg
  import bar_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  tgt_e          tgt_d,
  input  logic [AW-1:0] addr_d,
  input  logic          err_d,
  output logic          valid_q,
  output logic          write_q,
  output tgt_e          tgt_q,
  output logic [AW-1:0] addr_q,
  output logic          err_q
);

  logic          valid_n;
  logic          write_n;
  tgt_e          tgt_n;
  logic [AW-1:0] addr_n;
  logic          err_n;
  logic          upd_en;

  always_comb begin
    upd_en  = req || valid_q;
    valid_n = req;
    write_n = req && wr;
    tgt_n   = req ? tgt_d : TGT_NONE;
    addr_n  = req ? addr_d : '0;
    err_n   = req && err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      tgt_q   <= TGT_NONE;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else if (upd_en) begin
      valid_q <= valid_n;
      write_q <= write_n;
      tgt_q   <= tgt_n;
      addr_q  <= addr_n;
      err_q   <= err_n;
    end
  end

  // R10: a strobe is reported on the next edge
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid_q);
  // R10: an idle cycle leaves an empty result
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (tgt_q == TGT_NONE && !err_q && addr_q == '0));
  // R6, R12: an error never carries a target
  a_r6_err_no_tgt: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> tgt_q == TGT_NONE);

endmodule

// File: rtl/bar_xlate.sv
module bar_xlate
  import bar_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    layout_sel,
  input  logic          prom_cap,
  input  logic          cfg_wr_en,
  input  logic          cfg_wr_sel,
  input  logic [AW-1:0] cfg_wr_data,
  input  logic          cfg_rd_sel,
  output logic [AW-1:0] cfg_rd_data,
  input  logic [OW-1:0] acc_off,
  input  logic          acc_rd,
  input  logic          acc_wr,
  output logic          out_valid,
  output logic          out_write,
  output logic [2:0]    out_tgt,
  output logic [AW-1:0] out_addr,
  output logic          out_err
);

  localparam int NWIN = 2;

  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  logic [NWIN-1:0][AW-1:0] win;
  logic                    req;
  tgt_e                    tgt_d;
  tgt_e                    tgt_q;
  logic [AW-1:0]           addr_d;
  logic                    err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign req = acc_rd || acc_wr;

  bar_xlate_winregs #(.AW(AW), .NWIN(NWIN)) u_winregs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .rd_sel  (cfg_rd_sel),
    .rd_data (cfg_rd_data),
    .win     (win)
  );

  bar_xlate_decode #(.AW(AW), .OW(OW)) u_decode (
    .layout   (layout_sel),
    .prom_cap (prom_cap),
    .req      (req),
    .off      (acc_off),
    .win0     (win[0]),
    .win1     (win[1]),
    .tgt      (tgt_d),
    .addr     (addr_d),
    .err      (err_d)
  );

  bar_xlate_outreg #(.AW(AW)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (req),
    .wr      (acc_wr),
    .tgt_d   (tgt_d),
    .addr_d  (addr_d),
    .err_d   (err_d),
    .valid_q (out_valid),
    .write_q (out_write),
    .tgt_q   (tgt_q),
    .addr_q  (out_addr),
    .err_q   (out_err)
  );

  assign out_tgt = tgt_q;

  // R3: the bottom page always lands in the first sliding window
  a_r3_low_page: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req && acc_off[OW-1:PAGE_W] == '0 && layout_sel != 2'd3)
      |=> (out_tgt == 3'd1 && out_addr[PAGE_W-1:0] == $past(acc_off[PAGE_W-1:0])));
  // R9: the PROM is reachable in the dual layout only with the capability set
  a_r9_prom_cap: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req && layout_sel == LAY_DUAL && !prom_cap) |=> out_tgt != 3'd2);
  // R12: a reserved layout always errors
  a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req && layout_sel == 2'd3) |=> out_err);
  // R10: the write flag follows the sampled strobe
  a_r10_write_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    req |=> out_write == $past(acc_wr));

endmodule

// File: tb/test_bar_xlate.sv
`timescale 1ns/1ps
module test_bar_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  layout_sel;
  logic        prom_cap;
  logic        cfg_wr_en;
  logic        cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic        cfg_rd_sel;
  logic [31:0] cfg_rd_data;
  logic [13:0] acc_off;
  logic        acc_rd;
  logic        acc_wr;
  logic        out_valid;
  logic        out_write;
  logic [2:0]  out_tgt;
  logic [31:0] out_addr;
  logic        out_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] bw [2];

  always #2.5 clk = ~clk;

  bar_xlate i_bar_xlate (
    .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel), .prom_cap(prom_cap),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .acc_off(acc_off), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .out_valid(out_valid), .out_write(out_write), .out_tgt(out_tgt),
    .out_addr(out_addr), .out_err(out_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference map built from the requirement text
  function automatic void model(input int lay, input int off, input bit cap,
                                output logic [2:0] t, output logic [31:0] a,
                                output logic e);
    t = 3'd0; a = 32'h0; e = 1'b0;
    if (lay == 3) begin e = 1'b1; return; end
    if (off < 'h1000) begin t = 3'd1; a = bw[0] + off; return; end
    if (lay == 0) begin
      if (off < 'h1800)      begin t = 3'd2; a = off - 'h1000; end
      else if (off < 'h1C00) begin t = 3'd3; a = off - 'h1800; end
      else if (off < 'h2000) begin t = 3'd3; a = off - 'h1C00 + 'hC00; end
      else e = 1'b1;
    end else if (lay == 1) begin
      if (off < 'h2000)      begin t = 3'd2; a = off - 'h1000; end
      else if (off < 'h3000) begin t = 3'd3; a = off - 'h2000; end
      else                   begin t = 3'd4; a = off - 'h3000; end
    end else begin
      if (off < 'h2000)      begin t = 3'd1; a = bw[1] + (off - 'h1000); end
      else if (off < 'h3000) begin t = 3'd3; a = off - 'h2000; end
      else if (off >= 'h3800 && cap) begin t = 3'd2; a = off - 'h3800; end
      else                   begin t = 3'd4; a = off - 'h3000; end
    end
  endfunction

  task automatic access(input string req, input int lay, input int off,
                        input bit cap, input bit wr);
    logic [2:0] t; logic [31:0] a; logic e;
    layout_sel = 2'(lay); prom_cap = cap;
    @(negedge clk);
    acc_off = 14'(off); acc_rd = !wr; acc_wr = wr;
    model(lay, off, cap, t, a, e);
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    check(req, "valid", {31'h0, out_valid}, 32'h1);
    check(req, "write", {31'h0, out_write}, {31'h0, wr});
    check(req, "tgt",   {29'h0, out_tgt}, {29'h0, t});
    check(req, "addr",  out_addr, a);
    check(req, "err",   {31'h0, out_err}, {31'h0, e});
  endtask

  task automatic wr_win(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    bw[sel] = d & 32'hFFFF_F000;
  endtask

  task automatic t_reset();
    cfg_rd_sel = 1'b0; #0.1;
    check("R1", "win0", cfg_rd_data, 32'h0);
    cfg_rd_sel = 1'b1; #0.1;
    check("R1", "win1", cfg_rd_data, 32'h0);
    check("R1", "valid", {31'h0, out_valid}, 32'h0);
    check("R1", "tgt", {29'h0, out_tgt}, 32'h0);
    check("R1", "err", {31'h0, out_err}, 32'h0);
  endtask

  task automatic t_winregs();
    wr_win(1'b0, 32'h1234_5FFF);
    cfg_rd_sel = 1'b0; #0.1;
    check("R2", "win0 aligned", cfg_rd_data, 32'h1234_5000);
    cfg_rd_sel = 1'b1; #0.1;
    check("R2", "win1 untouched", cfg_rd_data, 32'h0);
    wr_win(1'b1, 32'hABCD_E123);
    check("R2", "win1 aligned", cfg_rd_data, 32'hABCD_E000);
    cfg_rd_sel = 1'b0; #0.1;
    check("R2", "win0 untouched", cfg_rd_data, 32'h1234_5000);
  endtask

  task automatic t_low_window();
    for (int l = 0; l < 3; l++) begin
      access("R3", l, 'h0000, 1'b0, 1'b0);
      access("R3", l, 'h0ABC, 1'b0, 1'b1);
      access("R3", l, 'h0FFF, 1'b1, 1'b0);
    end
  endtask

  task automatic t_layout8k();
    access("R4", 0, 'h1000, 1'b0, 1'b0);
    access("R4", 0, 'h17FF, 1'b0, 1'b1);
    access("R5", 0, 'h1800, 1'b0, 1'b0);
    access("R5", 0, 'h1BFF, 1'b0, 1'b0);
    access("R5", 0, 'h1C00, 1'b0, 1'b1);
    access("R5", 0, 'h1FFF, 1'b0, 1'b0);
    access("R6", 0, 'h2000, 1'b0, 1'b0);
    access("R6", 0, 'h3FFF, 1'b1, 1'b1);
  endtask

  task automatic t_layout16k();
    access("R7", 1, 'h1000, 1'b0, 1'b0);
    access("R7", 1, 'h1FFF, 1'b1, 1'b0);
    access("R7", 1, 'h2000, 1'b0, 1'b1);
    access("R7", 1, 'h2FFF, 1'b0, 1'b0);
    access("R7", 1, 'h3000, 1'b0, 1'b0);
    access("R7", 1, 'h3FFF, 1'b1, 1'b0);
  endtask

  task automatic t_dual();
    access("R8", 2, 'h1000, 1'b0, 1'b0);
    access("R8", 2, 'h1FFF, 1'b0, 1'b1);
    access("R8", 2, 'h2345, 1'b1, 1'b0);
  endtask

  task automatic t_prom_cap();
    access("R9", 2, 'h3800, 1'b1, 1'b0);
    access("R9", 2, 'h3FFF, 1'b1, 1'b0);
    access("R9", 2, 'h3800, 1'b0, 1'b0);
    access("R9", 2, 'h3FFF, 1'b0, 1'b1);
    access("R9", 2, 'h37FF, 1'b1, 1'b0);
    access("R9", 2, 'h3000, 1'b1, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    check("R10", "idle valid", {31'h0, out_valid}, 32'h0);
    check("R10", "idle tgt", {29'h0, out_tgt}, 32'h0);
    check("R10", "idle addr", out_addr, 32'h0);
    check("R10", "idle err", {31'h0, out_err}, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] old0, old1;
    old0 = bw[0]; old1 = bw[1];
    layout_sel = 2'd2; prom_cap = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 32'h7777_7000;
    acc_off = 14'h0123; acc_rd = 1'b1; acc_wr = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b0; acc_rd = 1'b0;
    check("R11", "old base win0", out_addr, old0 | 32'h123);
    bw[0] = 32'h7777_7000;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b1; cfg_wr_data = 32'h0BAD_C000;
    acc_off = 14'h1456; acc_wr = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; acc_wr = 1'b0;
    check("R11", "old base win1", out_addr, old1 | 32'h456);
    bw[1] = 32'h0BAD_C000;
    access("R11", 2, 'h0123, 1'b0, 1'b0);
    access("R11", 2, 'h1456, 1'b0, 1'b0);
  endtask

  task automatic t_reserved();
    access("R12", 3, 'h0000, 1'b0, 1'b0);
    access("R12", 3, 'h1800, 1'b1, 1'b1);
    access("R12", 3, 'h3FFF, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; layout_sel = 2'd0; prom_cap = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_sel = 1'b0; cfg_wr_data = '0; cfg_rd_sel = 1'b0;
    acc_off = '0; acc_rd = 1'b0; acc_wr = 1'b0;
    bw[0] = '0; bw[1] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_winregs();
    t_low_window();
    t_layout8k();
    t_layout16k();
    t_dual();
    t_prom_cap();
    t_idle();
    t_same_cycle();
    t_reserved();
    t_idle();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule